// File: doc/BRIEF.md
# Dual Channel Tone Generator

This block produces two independent square-wave voices for a small speaker or buzzer. Each channel owns a down-counting reload timer loaded with a tone period by software. While the tone mode input is high, every expiry of a channel's timer flips that channel's square wave in hardware, so the tones run without any interrupt service. The timers also raise a one-cycle tick flag per expiry in either mode, so they can serve as plain interval timers when the tone mode is off.

Each square wave is gated by a simple pulse-width stage. A free-running 16-step frame counter is shared by both channels and compared against a per-channel 4-bit envelope level. The output is high for `level` of every 16 cycles while the square wave is high. Software computes the envelope over time and writes new levels through the same register write port used for the periods.

Top module: `dual_tone_gen`

## Requirements
- R1: After reset, all period, level, counter and square-wave state is zero. Both tone outputs are low in the first cycle after reset is released.
- R2: Each channel's counter decrements by one per cycle. In the cycle after the counter reads zero, it reloads from the period register. The channel's tick flag is high exactly in the cycles where its counter reads zero, so a period P gives one tick every P+1 cycles and period 0 gives a tick on every cycle.
- R3: A period write changes only the period register. The running count is not altered, and the new value is loaded at the next reload.
- R4: While tone mode is high, a channel's square wave inverts on every cycle in which its counter reads zero.
- R5: While tone mode is low, both tone outputs are low and both square waves are cleared to low. Counters and tick flags keep running.
- R6: The frame counter is 4 bits wide, starts at 0 after reset, and advances by one per cycle, wrapping from 15 to 0. A channel's tone output is high when tone mode is high, its square wave is high, and the frame count is below its level.
- R7: A level of 0 holds the channel's tone output low from the cycle after the write.
- R8: Write decode uses `wr_addr` as follows. 0 is the channel 0 period, 1 is the channel 1 period, 2 is the channel 0 level and 3 is the channel 1 level. Periods take all 12 data bits and levels take data bits 3:0. A write to one channel leaves the other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Register select: 0/1 channel period, 2/3 channel level |
| wr_data | input | 12 | Write data |
| tone_mode | input | 1 | High enables hardware tone toggling and the outputs |
| tone_out | output | 2 | Modulated tone output per channel |
| tick_irq | output | 2 | Per-channel timer expiry flag |

## Verification
A write sampled on a clock edge changes register state at that edge. Its effect on `tick_irq` and `tone_out` is visible in the same cycle that follows, and a new period shows up only after the next reload. `tone_mode` reaches the outputs with no register in between, while its effect on the square-wave state lands one edge later. The bench advances a behavioural model on each rising edge from the same inputs the design sees. It compares both outputs on the falling edge, before new inputs are driven, so every expected value sits in exactly the cycle these latencies predict.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    parameter int unsigned DTG_CH    = 2;
    parameter int unsigned DTG_TMR_W = 12;
    parameter int unsigned DTG_LVL_W = 4;
endpackage

// File: rtl/dtg_frame.sv
module dtg_frame #(
    parameter int unsigned LVL_W = dtg_pkg::DTG_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LVL_W-1:0] frame
);
    typedef struct packed {
        logic [LVL_W-1:0] step;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.step = fr_q.step + LVL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign frame = fr_q.step;
endmodule

// File: rtl/dtg_channel.sv
module dtg_channel #(
    parameter int unsigned TMR_W = dtg_pkg::DTG_TMR_W,
    parameter int unsigned LVL_W = dtg_pkg::DTG_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic             lvl_we,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             mode,
    input  logic [LVL_W-1:0] frame,
    output logic             tone,
    output logic             tick
);
    typedef struct packed {
        logic [TMR_W-1:0] per;
        logic [TMR_W-1:0] cnt;
        logic [LVL_W-1:0] lvl;
        logic             sq;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  expire;

    always_comb begin
        ch_d   = ch_q;
        expire = (ch_q.cnt == '0);
        if (expire) ch_d.cnt = ch_q.per;
        else        ch_d.cnt = ch_q.cnt - TMR_W'(1);
        if (!mode)       ch_d.sq = 1'b0;
        else if (expire) ch_d.sq = ~ch_q.sq;
        if (per_we) ch_d.per = wr_data;
        if (lvl_we) ch_d.lvl = wr_data[LVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign tick = expire;
    assign tone = ch_q.sq & mode & (frame < ch_q.lvl);
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
    parameter int unsigned CH    = dtg_pkg::DTG_CH,
    parameter int unsigned TMR_W = dtg_pkg::DTG_TMR_W,
    parameter int unsigned LVL_W = dtg_pkg::DTG_LVL_W,
    localparam int unsigned ADDR_W = $clog2(2 * CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    input  logic              tone_mode,
    output logic [CH-1:0]     tone_out,
    output logic [CH-1:0]     tick_irq
);
    logic [LVL_W-1:0] frame;

    dtg_frame #(.LVL_W(LVL_W)) frame_i (
        .clk   (clk),
        .rst_n (rst_n),
        .frame (frame)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(c);
        localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(CH + c);
        logic per_we, lvl_we;

        assign per_we = wr_en && (wr_addr == PER_A);
        assign lvl_we = wr_en && (wr_addr == LVL_A);

        dtg_channel #(.TMR_W(TMR_W), .LVL_W(LVL_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .per_we  (per_we),
            .lvl_we  (lvl_we),
            .wr_data (wr_data),
            .mode    (tone_mode),
            .frame   (frame),
            .tone    (tone_out[c]),
            .tick    (tick_irq[c])
        );
    end
endmodule

module dual_tone_gen_chk #(
    parameter int unsigned CH    = 2,
    parameter int unsigned TMR_W = 12,
    parameter int unsigned LVL_W = 4,
    localparam int unsigned ADDR_W = $clog2(2 * CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [TMR_W-1:0]  wr_data,
    input logic              tone_mode,
    input logic [CH-1:0]     tone_out,
    input logic [CH-1:0]     tick_irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tone_out == '0));

    // R5
    mode_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_mode |-> (tone_out == '0));

    for (genvar c = 0; c < CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(CH + c);

        // R7
        level_zero_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == LVL_A && wr_data[LVL_W-1:0] == '0) |=> !tone_out[c]);

        // R4
        rise_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tone_out[c]) |-> tone_mode);
    end
endmodule

bind dual_tone_gen dual_tone_gen_chk #(.CH(CH), .TMR_W(TMR_W), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tone_mode (tone_mode),
    .tone_out  (tone_out),
    .tick_irq  (tick_irq)
);

// File: tb/dual_tone_gen_tb_top.sv
`timescale 1ns/1ps
module dual_tone_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        tone_mode = 1'b0;
    logic [1:0]  tone_out;
    logic [1:0]  tick_irq;

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    int m_per [2];
    int m_cnt [2];
    int m_lvl [2];
    int m_sq  [2];
    int m_fr;

    always #2 clk = ~clk;

    dual_tone_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tone_mode(tone_mode),
        .tone_out(tone_out), .tick_irq(tick_irq)
    );

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_per[c] = 0; m_cnt[c] = 0; m_lvl[c] = 0; m_sq[c] = 0;
        end
        m_fr = 0;
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_per[c] = 0; m_cnt[c] = 0; m_lvl[c] = 0; m_sq[c] = 0;
            end
            m_fr = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit ex;
                ex = (m_cnt[c] == 0);
                m_cnt[c] = ex ? m_per[c] : m_cnt[c] - 1;
                if (!tone_mode) m_sq[c] = 0;
                else if (ex)    m_sq[c] = 1 - m_sq[c];
            end
            m_fr = (m_fr + 1) % 16;
            if (wr_en) begin
                if (wr_addr < 2) m_per[wr_addr] = int'(wr_data);
                else             m_lvl[wr_addr - 2] = int'(wr_data) % 16;
            end
        end
    end

    task automatic compare();
        logic [1:0] e_tone, e_irq;
        for (int c = 0; c < 2; c++) begin
            e_irq[c]  = (m_cnt[c] == 0);
            e_tone[c] = (m_sq[c] == 1) && tone_mode && (m_fr < m_lvl[c]);
        end
        vectors++;
        if (tone_out !== e_tone || tick_irq !== e_irq) begin
            errors++;
            $display("FAIL %s tone_out=%b exp=%b tick_irq=%b exp=%b",
                     cur_req, tone_out, e_tone, tick_irq, e_irq);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        cyc();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        vectors++;
        if (tone_out !== 2'b00) begin
            errors++;
            $display("FAIL R1 tone_out=%b exp=00", tone_out);
        end
        run(5);

        // R8 / R2: program both channels, mode off
        cur_req = "R8";
        wr(2'd0, 12'd5);
        wr(2'd1, 12'd9);
        wr(2'd2, 12'd15);
        wr(2'd3, 12'd15);
        cur_req = "R5";
        run(60);

        // R4: tone toggling
        cur_req = "R4";
        tone_mode = 1'b1;
        run(200);

        // R6: partial duty
        cur_req = "R6";
        wr(2'd2, 12'd8);
        wr(2'd3, 12'd3);
        run(200);

        // R3: period changes mid count
        cur_req = "R3";
        wr(2'd0, 12'd20);
        run(100);
        wr(2'd1, 12'd2);
        run(60);

        // R7: level zero mutes
        cur_req = "R7";
        wr(2'd2, 12'hFF0);
        run(60);

        // R5: mode off then on again
        cur_req = "R5";
        tone_mode = 1'b0;
        run(40);
        tone_mode = 1'b1;
        run(40);

        // R2: period zero ticks every cycle
        cur_req = "R2";
        wr(2'd2, 12'd12);
        wr(2'd0, 12'd0);
        wr(2'd1, 12'd0);
        run(40);

        // R8: scattered writes and mode changes
        cur_req = "R8";
        for (int i = 0; i < 300; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[31:28] == 4'hF) tone_mode = ~tone_mode;
            wr(lcg[9:8], {4'h0, lcg[23:16]} >> lcg[27:26]);
            run(int'(lcg[5:2]));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule